// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a 32-bit core datapath and a word-wide data memory. For stores it takes the access size and the byte offset within the word. It drives the low byte, the low halfword or the whole register onto the memory lanes that the offset selects, with one write strobe per lane. For loads it waits for the memory word that arrives one cycle after the request. It then pulls out the addressed byte, halfword or word. It widens a byte or halfword to 32 bits, by sign extension or by zero fill as the unsigned select asks.

Lane order is big endian. The byte at offset 0 of a word is the most significant byte. Offset 0 is data bits [31:24], offset 1 is [23:16], offset 2 is [15:8] and offset 3 is [7:0]. Strobe bit 3 enables the lane at offset 0 and strobe bit 0 the lane at offset 3. The access size code is 00 for byte, 01 for halfword, 10 for word and 11 reserved. A halfword at an odd offset, a word at a non-zero offset, or the reserved size is misaligned. A misaligned access raises the error flag and writes nothing.

A two-state machine tracks the load data phase. In LS_IDLE, an aligned load request takes the issue transition to LS_CAPTURE, and anything else holds LS_IDLE. In LS_CAPTURE the incoming memory word is captured into the load result. A new aligned load request in the same cycle takes the chain transition and stays in LS_CAPTURE. Otherwise the retire transition returns to LS_IDLE. Store outputs and the error flag are registered and come out one cycle after the request. Store outputs do not depend on the state, so a store can be accepted in the same cycle as a load data phase.

Top module: `be_lane_unit`

## Requirements
- R1: While reset is asserted, and after it until the first request, mem_wstrb is 0000, misalign is low and ld_valid is low.
- R2: After an aligned load request in cycle N, the memory word is read from mem_rdata in cycle N+1, and ld_valid with ld_data appear in cycle N+2. For a byte load, offset k takes the byte at bits [31-8k:24-8k].
- R3: With req_unsigned low, a byte or halfword load copies bit 7 or bit 15 of the selected value into every higher bit of ld_data.
- R4: With req_unsigned high, a byte or halfword load fills every bit of ld_data above the selected value with zeros.
- R5: A halfword load at offset 0 takes bits [31:16] and at offset 2 takes bits [15:0].
- R6: A word load at offset 0 returns the whole memory word whatever req_unsigned is.
- R7: A byte store at offset k drives strobe 4'b1000 shifted right by k, and places req_wdata[7:0] on that lane.
- R8: A halfword store at offset 0 drives strobe 1100, and at offset 2 drives strobe 0011. It places req_wdata[15:8] on the lower-offset lane and req_wdata[7:0] on the other.
- R9: A word store at offset 0 drives strobe 1111 with req_wdata on the lanes unchanged.
- R10: In the cycle after a misaligned request (halfword at odd offset, word at a non-zero offset, or size 11), misalign is high and mem_wstrb is 0000. A misaligned load produces no ld_valid.
- R11: mem_wstrb is 0000 in every cycle that does not follow an aligned store request, including the cycle after a load.
- R12: Back-to-back aligned loads each return their own result in consecutive cycles. A store issued in the cycle of a load's data phase gets its strobes in the same cycle as that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-fill instead of sign-extend on byte and halfword loads |
| req_off | input | 2 | Byte offset within the word |
| req_wdata | input | 32 | Register value to store |
| mem_rdata | input | 32 | Memory word, valid the cycle after a load request |
| mem_wstrb | output | 4 | Per-lane write strobes, bit 3 is offset 0 |
| mem_wdata | output | 32 | Lane-steered store data |
| misalign | output | 1 | Misaligned or reserved-size access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Store steering and load extraction can fall in the same cycle. A store issued while an earlier load's word is being captured has its strobes come out in the same cycle as that load's result. The bench provokes this with a load request followed at once by a store request. A second case is a load followed at once by another load. A per-cycle expectation queue and a separate load-result queue are checked independently. So a strobe that leaks from the load path, or a result that is lost or doubled, shows up as a mismatch in the right cycle.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        LS_IDLE    = 1'b0,
        LS_CAPTURE = 1'b1
    } ls_state_e;

endpackage

// File: rtl/be_align_check.sv
module be_align_check
    import be_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    output logic               bad
);
    always_comb begin
        case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = (off != '0);
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/be_store_steer.sv
module be_store_steer
    import be_lane_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = $clog2(LANES),
    parameter int DW    = 8 * LANES
) (
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DW-1:0]      src,
    output logic [LANES-1:0]   strb,
    output logic [DW-1:0]      data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LOFF = OFF_W'(LANES - 1 - i);
        logic       l_en;
        logic [7:0] l_byte;
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    l_en   = (off == LOFF);
                    l_byte = src[7:0];
                end
                SZ_HALF: begin
                    l_en   = (off[OFF_W-1:1] == LOFF[OFF_W-1:1]);
                    l_byte = LOFF[0] ? src[7:0] : src[15:8];
                end
                default: begin
                    l_en   = 1'b1;
                    l_byte = src[8*i +: 8];
                end
            endcase
        end
        assign strb[i]        = l_en;
        assign data[8*i +: 8] = l_byte;
    end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
    import be_lane_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = $clog2(LANES),
    parameter int DW    = 8 * LANES
) (
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   off,
    input  logic               uns,
    input  logic [DW-1:0]      word,
    output logic [DW-1:0]      value
);
    logic [DW-1:0] sh_b;
    logic [DW-1:0] sh_h;
    logic [7:0]    b_v;
    logic [15:0]   h_v;
    logic          fill;

    always_comb begin
        sh_b  = word >> (8 * (LANES - 1 - int'(off)));
        sh_h  = word >> (8 * (LANES - 2 - int'({off[OFF_W-1:1], 1'b0})));
        b_v   = sh_b[7:0];
        h_v   = sh_h[15:0];
        fill  = 1'b0;
        case (size)
            SZ_BYTE: begin
                fill  = ~uns & b_v[7];
                value = {{(DW-8){fill}}, b_v};
            end
            SZ_HALF: begin
                fill  = ~uns & h_v[15];
                value = {{(DW-16){fill}}, h_v};
            end
            default: value = word;
        endcase
    end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic                    req_unsigned,
    input  logic [1:0]              req_off,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [DATA_W/8-1:0]     mem_wstrb,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    misalign,
    output logic                    ld_valid,
    output logic [DATA_W-1:0]       ld_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    acc_size_e          size_in;
    logic               mis_now;
    logic               load_go;
    logic [LANES-1:0]   strb_c;
    logic [DATA_W-1:0]  wdat_c;
    logic [DATA_W-1:0]  ext_c;

    ls_state_e          state_q, state_d;
    acc_size_e          cap_size_q;
    logic [OFF_W-1:0]   cap_off_q;
    logic               cap_uns_q;

    assign size_in = acc_size_e'(req_size);
    assign load_go = req_valid & ~req_write & ~mis_now;

    be_align_check #(.OFF_W(OFF_W)) u_align (
        .size (size_in),
        .off  (req_off),
        .bad  (mis_now)
    );

    be_store_steer #(.LANES(LANES), .OFF_W(OFF_W), .DW(DATA_W)) u_steer (
        .size (size_in),
        .off  (req_off),
        .src  (req_wdata),
        .strb (strb_c),
        .data (wdat_c)
    );

    be_load_extract #(.LANES(LANES), .OFF_W(OFF_W), .DW(DATA_W)) u_extract (
        .size  (cap_size_q),
        .off   (cap_off_q),
        .uns   (cap_uns_q),
        .word  (mem_rdata),
        .value (ext_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE:    state_d = load_go ? LS_CAPTURE : LS_IDLE;
            LS_CAPTURE: state_d = load_go ? LS_CAPTURE : LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LS_IDLE;
            cap_size_q <= SZ_BYTE;
            cap_off_q  <= '0;
            cap_uns_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_go) begin
                cap_size_q <= size_in;
                cap_off_q  <= req_off;
                cap_uns_q  <= req_unsigned;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_wstrb <= '0;
            mem_wdata <= '0;
            misalign  <= 1'b0;
            ld_valid  <= 1'b0;
            ld_data   <= '0;
        end else begin
            mem_wstrb <= (req_valid && req_write && !mis_now) ? strb_c : '0;
            if (req_valid && req_write) mem_wdata <= wdat_c;
            misalign  <= req_valid & mis_now;
            ld_valid  <= (state_q == LS_CAPTURE);
            if (state_q == LS_CAPTURE) ld_data <= ext_c;
        end
    end
endmodule

// File: rtl/be_lane_unit_checks.sv
module be_lane_unit_checks #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [1:0]         req_size,
    input logic [1:0]         req_off,
    input logic [LANES-1:0]   mem_wstrb,
    input logic               misalign,
    input logic               ld_valid
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (mem_wstrb == '0 && !misalign && !ld_valid); // R1
        end
    end

    AST_MISALIGN_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> mem_wstrb == '0); // R10

    AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write) |-> mem_wstrb == '0); // R11

    AST_LDV_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_write, 2)); // R2

    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_size == 2'b10 && req_off == 2'b00)
        |-> mem_wstrb == '1); // R9

    AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wstrb != '0) |-> ($countones(mem_wstrb) == 1 || $countones(mem_wstrb) == 2
                               || $countones(mem_wstrb) == LANES)); // R8
endmodule

bind be_lane_unit be_lane_unit_checks #(.LANES(DATA_W/8)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_off   (req_off),
    .mem_wstrb (mem_wstrb),
    .misalign  (misalign),
    .ld_valid  (ld_valid)
);

// File: tb/be_lane_unit_test.sv
module be_lane_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [1:0]  req_off = 2'b00;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] drv_word = '0;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic        ld_valid;
    logic [31:0] ld_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { logic [3:0] strb; logic [31:0] wdata; logic mis; string tag; } cyc_t;
    typedef struct { logic [31:0] data; string tag; } ld_t;
    cyc_t cq[$];
    ld_t  lq[$];

    always #5 clk = ~clk;
    always @(posedge clk) mem_rdata <= drv_word;

    be_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_off(req_off),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_bad(logic [1:0] sz, logic [1:0] off);
        return (sz == 2'b11) || (sz == 2'b01 && off[0]) || (sz == 2'b10 && off != 2'b00);
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] w, logic [1:0] sz, logic uns, logic [1:0] off);
        logic [31:0] v;
        if (sz == 2'b00) begin
            v = (w >> (24 - 8 * off)) & 32'hFF;
            if (!uns && v[7]) v = v | 32'hFFFF_FF00;
        end else if (sz == 2'b01) begin
            v = (w >> (16 - 8 * off)) & 32'hFFFF;
            if (!uns && v[15]) v = v | 32'hFFFF_0000;
        end else v = w;
        return v;
    endfunction

    task automatic issue(logic wr, logic [1:0] sz, logic uns, logic [1:0] off,
                         logic [31:0] src, logic [31:0] word, string tag);
        cyc_t c;
        ld_t  l;
        logic bad;
        @(negedge clk);
        bad = exp_bad(sz, off);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = uns;
        req_off = off; req_wdata = src; drv_word = word;
        c.mis = bad; c.tag = tag; c.strb = 4'b0000; c.wdata = '0;
        if (wr && !bad) begin
            if (sz == 2'b00) begin c.strb = 4'b1000 >> off; c.wdata = {4{src[7:0]}}; end
            else if (sz == 2'b01) begin c.strb = 4'b1100 >> off; c.wdata = {2{src[15:0]}}; end
            else begin c.strb = 4'b1111; c.wdata = src; end
        end
        cq.push_back(c);
        if (!wr && !bad) begin
            l.data = exp_load(word, sz, uns, off);
            l.tag = tag;
            lq.push_back(l);
        end
    endtask

    task automatic idle(int n);
        cyc_t c;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
            c.strb = 4'b0000; c.wdata = '0; c.mis = 1'b0; c.tag = "R11";
            cq.push_back(c);
        end
    endtask

    initial begin : monitor
        cyc_t c;
        ld_t  l;
        logic [31:0] m;
        forever begin
            @(posedge clk);
            #2;
            if (cq.size() > 0) begin
                c = cq.pop_front();
                check(c.tag, "strb", {28'd0, mem_wstrb}, {28'd0, c.strb});
                check(c.tag, "misalign", {31'd0, misalign}, {31'd0, c.mis});
                if (c.strb != 4'b0000) begin
                    m = {{8{c.strb[3]}}, {8{c.strb[2]}}, {8{c.strb[1]}}, {8{c.strb[0]}}};
                    check(c.tag, "wdata", mem_wdata & m, c.wdata & m);
                end
            end
            if (ld_valid) begin
                if (lq.size() == 0) check("R10", "unexpected ld_valid", 32'd1, 32'd0);
                else begin
                    l = lq.pop_front();
                    check(l.tag, "ld_data", ld_data, l.data);
                end
            end
        end
    end

    initial begin : watchdog
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : driver
        logic [31:0] wa;
        logic [31:0] wb;
        wa = 32'h8A3C_F105;
        wb = 32'h7F80_0102;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "strb in reset", {28'd0, mem_wstrb}, 32'd0);
        check("R1", "misalign in reset", {31'd0, misalign}, 32'd0);
        check("R1", "ld_valid in reset", {31'd0, ld_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "strb after reset", {28'd0, mem_wstrb}, 32'd0);
        check("R1", "ld_valid after reset", {31'd0, ld_valid}, 32'd0);
        idle(1);
        // byte loads, signed (R2, R3) and unsigned (R4)
        for (int k = 0; k < 4; k++) begin
            issue(1'b0, 2'b00, 1'b0, 2'(k), '0, wa, "R3");
            idle(2);
        end
        for (int k = 0; k < 4; k++) begin
            issue(1'b0, 2'b00, 1'b1, 2'(k), '0, wa, "R4");
            idle(2);
        end
        issue(1'b0, 2'b00, 1'b0, 2'd1, '0, wb, "R2"); idle(2);
        // halfword loads (R5)
        issue(1'b0, 2'b01, 1'b0, 2'd0, '0, wa, "R5"); idle(2);
        issue(1'b0, 2'b01, 1'b0, 2'd2, '0, wa, "R5"); idle(2);
        issue(1'b0, 2'b01, 1'b1, 2'd0, '0, wa, "R4"); idle(2);
        issue(1'b0, 2'b01, 1'b0, 2'd0, '0, wb, "R5"); idle(2);
        issue(1'b0, 2'b01, 1'b0, 2'd2, '0, wb, "R5"); idle(2);
        // word loads (R6)
        issue(1'b0, 2'b10, 1'b1, 2'd0, '0, wa, "R6"); idle(2);
        issue(1'b0, 2'b10, 1'b0, 2'd0, '0, wb, "R6"); idle(2);
        // stores (R7, R8, R9)
        for (int k = 0; k < 4; k++) issue(1'b1, 2'b00, 1'b0, 2'(k), 32'h1234_56AB, '0, "R7");
        issue(1'b1, 2'b01, 1'b0, 2'd0, 32'hDEAD_BEEF, '0, "R8");
        issue(1'b1, 2'b01, 1'b0, 2'd2, 32'hDEAD_BEEF, '0, "R8");
        issue(1'b1, 2'b10, 1'b0, 2'd0, 32'hCAFE_0911, '0, "R9");
        idle(1);
        // misaligned (R10)
        issue(1'b1, 2'b01, 1'b0, 2'd1, 32'h0000_5A5A, '0, "R10");
        issue(1'b1, 2'b01, 1'b0, 2'd3, 32'h0000_5A5A, '0, "R10");
        issue(1'b1, 2'b10, 1'b0, 2'd2, 32'h1111_2222, '0, "R10");
        issue(1'b1, 2'b11, 1'b0, 2'd0, 32'h1111_2222, '0, "R10");
        issue(1'b0, 2'b10, 1'b0, 2'd1, '0, wa, "R10");
        issue(1'b0, 2'b01, 1'b0, 2'd3, '0, wa, "R10");
        idle(3);
        // back-to-back (R12)
        issue(1'b0, 2'b00, 1'b0, 2'd0, '0, wa, "R12");
        issue(1'b1, 2'b00, 1'b0, 2'd3, 32'h0000_00C3, '0, "R12");
        idle(2);
        issue(1'b0, 2'b00, 1'b1, 2'd2, '0, wa, "R12");
        issue(1'b0, 2'b01, 1'b0, 2'd2, '0, wb, "R12");
        issue(1'b0, 2'b10, 1'b0, 2'd0, '0, wa, "R12");
        issue(1'b1, 2'b01, 1'b0, 2'd0, 32'h0000_A55A, '0, "R12");
        idle(4);
        @(negedge clk);
        check("R12", "loads left unanswered", 32'(lq.size()), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule